// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block collects level-sensitive interrupt requests from a group of devices that sit on one bus and folds them onto a small set of shared interrupt lines. Every device drives four request pins. The block remembers the last level it saw on each pin. A pin whose level has not changed is ignored. A pin that rises adds one to the reference counter of the shared line it routes to. A pin that falls subtracts one. A shared line is high for as long as its counter is nonzero.

Routing runs through a swizzle chosen at build time. The default rotates each device's pins by its device number, which spreads devices evenly over the lines. A direct mode sends pin p of every device to line p. For save and restore, a readback port exposes every counter, the line count and the stored pin levels. A restore request reloads counters and pin levels in a single cycle. The restore is refused if the line count it carries differs from the block's own.

Top module: `irq_share_agg`

## Requirements
- R1: While rst_ni is low, every counter, every stored pin level, every bit of line_o and restore_err_o read zero.
- R2: In a cycle with no restore request, a pin whose input equals its stored level leaves every counter unchanged.
- R3: A pin whose stored level is 0 and whose input is 1 adds one to the counter of its routed line at the next clock edge.
- R4: A pin whose stored level is 1 and whose input is 0 subtracts one from the counter of its routed line at the next clock edge.
- R5: Bit l of line_o is 1 exactly when the counter of line l is nonzero.
- R6: Pin p of device d is bit d*4+p of irq_i. In the default rotate mode it routes to line (p + d) mod NUM_LINES. In direct mode it routes to line p mod NUM_LINES.
- R7: All pin changes in one cycle are applied together, and each counter moves by the number of rises minus the number of falls routed to it.
- R8: rd_cnt_o shows the counter of line rd_sel_i in the same cycle. lines_o shows NUM_LINES. pin_state_o shows the stored level of every pin, using the same bit order as irq_i.
- R9: A restore request whose restore_lines_i equals NUM_LINES loads counter l from restore_cnt_i[l*CW +: CW] and the stored levels from restore_lvl_i at the next edge. irq_i is ignored in that cycle.
- R10: A restore request whose restore_lines_i differs from NUM_LINES changes no counter and no stored level. restore_err_o is 1 in the following cycle only.
- R11: The counters are wide enough that all NUM_DEV*4 pins held high produce the exact count on each line without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_DEV*4 | Pin levels; device d pin p at bit d*4+p |
| line_o | output | NUM_LINES | Shared line levels |
| rd_sel_i | input | SW | Line selected for counter readback |
| rd_cnt_o | output | CW | Counter of the selected line |
| lines_o | output | LW | Number of lines |
| pin_state_o | output | NUM_DEV*4 | Stored pin levels |
| restore_i | input | 1 | Restore request |
| restore_lines_i | input | LW | Line count carried by the restore |
| restore_cnt_i | input | NUM_LINES*CW | Counter values to load, line l at l*CW |
| restore_lvl_i | input | NUM_DEV*4 | Pin levels to load |
| restore_err_o | output | 1 | Previous restore was rejected |

## Verification
Two functions can fall in the same cycle: a restore request and pin changes on irq_i. The bench drives a restore, accepted or refused, while several pins differ from their stored levels. It then checks that none of those changes reached a counter and that, on the next cycle, change detection compares against the restored levels. Several rises and falls routed to the same line in one cycle are also driven together. The net counter value is judged against a behavioural model every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned PINS_PER_DEV = 4;

  typedef enum logic [0:0] {
    ROUTE_ROTATE = 1'b0,
    ROUTE_DIRECT = 1'b1
  } route_mode_e;

  function automatic int unsigned route_line(int unsigned dev, int unsigned pin,
                                             route_mode_e mode, int unsigned lines);
    if (mode == ROUTE_ROTATE) return (pin + dev) % lines;
    return pin % lines;
  endfunction

endpackage

// File: rtl/irq_agg_route.sv
module irq_agg_route #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned NUM_LINES = 4,
  parameter irq_agg_pkg::route_mode_e ROUTE_MODE = irq_agg_pkg::ROUTE_ROTATE,
  localparam int unsigned NP = NUM_DEV * irq_agg_pkg::PINS_PER_DEV
) (
  input  logic [NP-1:0] irq_i,
  input  logic [NP-1:0] lvl_i,
  input  logic          hold_i,
  output logic [NP-1:0] rise_o [NUM_LINES],
  output logic [NP-1:0] fall_o [NUM_LINES]
);

  logic [NP-1:0] up, dn;

  assign up = hold_i ? '0 : (irq_i & ~lvl_i);
  assign dn = hold_i ? '0 : (~irq_i & lvl_i);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    for (genvar p = 0; p < irq_agg_pkg::PINS_PER_DEV; p++) begin : g_pin
      localparam int unsigned IDX = d * irq_agg_pkg::PINS_PER_DEV + p;
      localparam int unsigned LN = irq_agg_pkg::route_line(d, p, ROUTE_MODE, NUM_LINES);
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        if (l == LN) begin : g_hit
          assign rise_o[l][IDX] = up[IDX];
          assign fall_o[l][IDX] = dn[IDX];
        end else begin : g_miss
          assign rise_o[l][IDX] = 1'b0;
          assign fall_o[l][IDX] = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/irq_agg_counter.sv
module irq_agg_counter #(
  parameter int unsigned NP = 16,
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] rise_i,
  input  logic [NP-1:0] fall_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW:0] n_up, n_dn, sum;
  logic [CW-1:0] cnt_q;

  always_comb begin
    n_up = '0;
    n_dn = '0;
    for (int i = 0; i < NP; i++) begin
      n_up = n_up + {{CW{1'b0}}, rise_i[i]};
      n_dn = n_dn + {{CW{1'b0}}, fall_i[i]};
    end
    sum = {1'b0, cnt_q} + n_up - n_dn;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= sum[CW-1:0];
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned NUM_LINES = 4,
  parameter irq_agg_pkg::route_mode_e ROUTE_MODE = irq_agg_pkg::ROUTE_ROTATE,
  localparam int unsigned NP = NUM_DEV * irq_agg_pkg::PINS_PER_DEV,
  localparam int unsigned CW = $clog2(NP + 1),
  localparam int unsigned LW = $clog2(NUM_LINES + 1),
  localparam int unsigned SW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NP-1:0]          irq_i,
  output logic [NUM_LINES-1:0]   line_o,
  input  logic [SW-1:0]          rd_sel_i,
  output logic [CW-1:0]          rd_cnt_o,
  output logic [LW-1:0]          lines_o,
  output logic [NP-1:0]          pin_state_o,
  input  logic                   restore_i,
  input  logic [LW-1:0]          restore_lines_i,
  input  logic [NUM_LINES*CW-1:0] restore_cnt_i,
  input  logic [NP-1:0]          restore_lvl_i,
  output logic                   restore_err_o
);

  logic [NP-1:0] lvl_q;
  logic          err_q;
  logic          restore_ok;
  logic [NP-1:0] rise [NUM_LINES];
  logic [NP-1:0] fall [NUM_LINES];
  logic [CW-1:0] cnt [NUM_LINES];
  logic [CW-1:0] cnt_pad [2**SW];
  logic [NUM_LINES*CW-1:0] cnt_flat;

  assign restore_ok = restore_i && (restore_lines_i == LW'(NUM_LINES));

  irq_agg_route #(
    .NUM_DEV   (NUM_DEV),
    .NUM_LINES (NUM_LINES),
    .ROUTE_MODE(ROUTE_MODE)
  ) u_route (
    .irq_i (irq_i),
    .lvl_i (lvl_q),
    .hold_i(restore_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_cnt
    irq_agg_counter #(.NP(NP), .CW(CW)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise[l]),
      .fall_i    (fall[l]),
      .load_i    (restore_ok),
      .load_val_i(restore_cnt_i[l*CW +: CW]),
      .cnt_o     (cnt[l])
    );
    assign line_o[l] = |cnt[l];
    assign cnt_flat[l*CW +: CW] = cnt[l];
  end

  for (genvar s = 0; s < 2**SW; s++) begin : g_pad
    if (s < NUM_LINES) begin : g_real
      assign cnt_pad[s] = cnt[s];
    end else begin : g_none
      assign cnt_pad[s] = '0;
    end
  end

  // stored levels follow inputs except during any restore request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= restore_i && !restore_ok;
      if (restore_ok)      lvl_q <= restore_lvl_i;
      else if (!restore_i) lvl_q <= irq_i;
    end
  end

  assign rd_cnt_o      = cnt_pad[rd_sel_i];
  assign lines_o       = LW'(NUM_LINES);
  assign pin_state_o   = lvl_q;
  assign restore_err_o = err_q;

endmodule

// File: rtl/irq_share_agg_chk.sv
module irq_share_agg_chk #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned NP = NUM_DEV * 4,
  localparam int unsigned CW = $clog2(NP + 1),
  localparam int unsigned LW = $clog2(NUM_LINES + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NP-1:0]           irq_i,
  input logic                    restore_i,
  input logic [LW-1:0]           restore_lines_i,
  input logic [NUM_LINES*CW-1:0] restore_cnt_i,
  input logic [NP-1:0]           pin_state_o,
  input logic                    restore_err_o,
  input logic [NUM_LINES*CW-1:0] cnt_flat_i
);

  a_r2_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restore_i && irq_i == pin_state_o) |=> $stable(cnt_flat_i));

  a_r8_state_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restore_i |=> pin_state_o == $past(irq_i));

  a_r9_restore_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && restore_lines_i == LW'(NUM_LINES)) |=> cnt_flat_i == $past(restore_cnt_i));

  a_r10_reject_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && restore_lines_i != LW'(NUM_LINES)) |=>
      ($stable(cnt_flat_i) && $stable(pin_state_o) && restore_err_o));

  a_r10_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restore_i |=> !restore_err_o);

endmodule

bind irq_share_agg irq_share_agg_chk #(
  .NUM_DEV  (NUM_DEV),
  .NUM_LINES(NUM_LINES)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .irq_i          (irq_i),
  .restore_i      (restore_i),
  .restore_lines_i(restore_lines_i),
  .restore_cnt_i  (restore_cnt_i),
  .pin_state_o    (pin_state_o),
  .restore_err_o  (restore_err_o),
  .cnt_flat_i     (cnt_flat)
);

// File: tb/irq_share_agg_test.sv
module irq_share_agg_test;

  localparam int ND = 4;
  localparam int NL = 4;
  localparam int NP = ND * 4;
  localparam int CW = $clog2(NP + 1);
  localparam int LW = $clog2(NL + 1);
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] irq = '0;
  logic [NL-1:0] line;
  logic [SW-1:0] rd_sel = '0;
  logic [CW-1:0] rd_cnt;
  logic [LW-1:0] lines;
  logic [NP-1:0] pin_state;
  logic restore = 1'b0;
  logic [LW-1:0] restore_lines = '0;
  logic [NL*CW-1:0] restore_cnt = '0;
  logic [NP-1:0] restore_lvl = '0;
  logic restore_err;

  int checks = 0;
  int errors = 0;
  int ref_cnt [NL];
  bit ref_lvl [NP];
  bit ref_err = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  irq_share_agg uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .line_o(line),
    .rd_sel_i(rd_sel), .rd_cnt_o(rd_cnt), .lines_o(lines),
    .pin_state_o(pin_state), .restore_i(restore),
    .restore_lines_i(restore_lines), .restore_cnt_i(restore_cnt),
    .restore_lvl_i(restore_lvl), .restore_err_o(restore_err)
  );

  function automatic int route(int i);
    return ((i % 4) + (i / 4)) % NL;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int l = 0; l < NL; l++) begin
      rd_sel = SW'(l);
      #1;
      chk(int'(rd_cnt) == ref_cnt[l], "R8 counter readback", int'(rd_cnt), ref_cnt[l]);
      chk(line[l] == (ref_cnt[l] != 0), "R5 line level", int'(line[l]), int'(ref_cnt[l] != 0));
    end
    for (int i = 0; i < NP; i++)
      chk(pin_state[i] == ref_lvl[i], "R8 pin state", int'(pin_state[i]), int'(ref_lvl[i]));
    chk(restore_err == ref_err, "R10 error flag", int'(restore_err), int'(ref_err));
    chk(int'(lines) == NL, "R8 line count", int'(lines), NL);
  endtask

  task automatic cycle();
    @(posedge clk);
    if (restore) begin
      if (int'(restore_lines) == NL) begin
        for (int l = 0; l < NL; l++) ref_cnt[l] = int'(restore_cnt[l*CW +: CW]);
        for (int i = 0; i < NP; i++) ref_lvl[i] = restore_lvl[i];
        ref_err = 0;
      end else begin
        ref_err = 1;
      end
    end else begin
      ref_err = 0;
      for (int i = 0; i < NP; i++) begin
        if (irq[i] != ref_lvl[i]) begin
          ref_cnt[route(i)] += irq[i] ? 1 : -1;
          ref_lvl[i] = irq[i];
        end
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic want_cnt(int l, int exp, string tag);
    rd_sel = SW'(l);
    #1;
    chk(int'(rd_cnt) == exp, tag, int'(rd_cnt), exp);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog (%s) actual=0 expected=1", phase);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) ref_cnt[l] = 0;
    for (int i = 0; i < NP; i++) ref_lvl[i] = 0;
    irq = '1;
    #35;
    // R1: reset holds everything at zero despite active inputs
    compare_all();
    @(negedge clk);
    rst_n = 1'b1;
    irq = '0;

    phase = "R2";
    for (int k = 0; k < 4; k++) cycle();

    phase = "R3";
    irq[0] = 1'b1;
    cycle();
    want_cnt(0, 1, "R3 rise on dev0 pin0");

    phase = "R6";
    irq[2*4+1] = 1'b1;
    cycle();
    want_cnt(3, 1, "R6 dev2 pin1 routes to line 3");

    phase = "R2";
    cycle();
    want_cnt(0, 1, "R2 unchanged level holds count");

    phase = "R4";
    irq[0] = 1'b0;
    cycle();
    want_cnt(0, 0, "R4 fall on dev0 pin0");
    chk(line[0] == 1'b0, "R5 line 0 low at zero", int'(line[0]), 0);

    phase = "R7";
    irq[1*4+3] = 1'b1;
    irq[3*4+1] = 1'b1;
    irq[2*4+1] = 1'b0;
    cycle();
    want_cnt(0, 2, "R7 two rises on line 0");
    want_cnt(3, 0, "R7 fall on line 3");

    phase = "R11";
    irq = '1;
    cycle();
    for (int l = 0; l < NL; l++) want_cnt(l, 4, "R11 all pins high");
    irq = '0;
    cycle();

    phase = "R7";
    for (int k = 0; k < 60; k++) begin
      irq = NP'($urandom);
      cycle();
    end

    phase = "R9";
    restore_lvl = 16'hA5C3;
    restore_cnt = '0;
    for (int i = 0; i < NP; i++)
      if (restore_lvl[i]) restore_cnt[route(i)*CW +: CW] += CW'(1);
    restore_lines = LW'(NL);
    restore = 1'b1;
    irq = ~irq;
    cycle();
    restore = 1'b0;
    irq = 16'hA5C3;
    cycle();
    irq = 16'h0000;
    cycle();
    want_cnt(0, 0, "R9 counts clear after restored pins fall");

    phase = "R10";
    irq = 16'h00F0;
    cycle();
    restore_lvl = '0;
    restore_cnt = '1;
    restore_lines = LW'(NL - 1);
    restore = 1'b1;
    irq = 16'hFFFF;
    cycle();
    restore = 1'b0;
    irq = 16'h00F0;
    cycle();
    chk(restore_err == 1'b0, "R10 error lasts one cycle", int'(restore_err), 0);
    for (int k = 0; k < 20; k++) begin
      irq = NP'($urandom);
      cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule